// File: doc/BRIEF.md
# Zero-Negate Function ALU

A purely combinational integer ALU built around a single core that can either add or AND. Each of the two operands passes through a conditioning stage before it reaches the core. That stage can first force the operand to all zeros and can then invert every bit of it.

The core produces a ripple-carry sum, which includes an explicit carry input, and a bitwise AND. One control bit picks which of the two results is used. A last stage can invert the chosen result before it leaves the block.

Two flags are derived from the final output: one reports an all-zero result and one reports a negative result. Six independent control bits plus the carry input yield the usual function set without any opcode decoding: constants, pass-through, negation, increment, decrement, subtraction in both directions, AND and OR.

Top module: `zn_alu`

## Requirements
- R1: When `x_zero` is 1, the X operand is replaced by all zeros before any other processing; when 0, X passes unchanged to the inversion step.
- R2: When `y_zero` is 1, the Y operand is replaced by all zeros; when 0, Y passes unchanged to the inversion step.
- R3: `x_inv` and `y_inv` invert every bit of their operand after zeroing, so a zeroed and inverted operand is all ones (0xFFFF at the default width).
- R4: `fn_add` = 1 selects the sum of the conditioned operands; `fn_add` = 0 selects their bitwise AND.
- R5: The sum is conditioned X + conditioned Y + `carry_in`, computed modulo 2^16; a carry out of bit 15 is discarded.
- R6: `out_inv` = 1 inverts every bit of the selected result before it reaches `result`.
- R7: `is_zero` is 1 exactly when every bit of `result` is 0.
- R8: `is_neg` equals bit 15 (the MSB) of `result`, so `is_zero` and `is_neg` are never both 1.
- R9: With `carry_in` = 0, the control settings zero/zero/add/no-invert give `result` = 0, and settings with every zero and invert control set together with `fn_add` = 1 give `result` = 1.
- R10: When `fn_add` = 0, `carry_in` has no effect on `result`.
- R11: The outputs follow the inputs without any clock: a change of an input settles on the outputs within the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| x_in | input | 16 | X operand |
| y_in | input | 16 | Y operand |
| x_zero | input | 1 | Force X to zero |
| x_inv | input | 1 | Invert X after zeroing |
| y_zero | input | 1 | Force Y to zero |
| y_inv | input | 1 | Invert Y after zeroing |
| fn_add | input | 1 | 1 selects the sum, 0 selects the AND |
| out_inv | input | 1 | Invert the selected result |
| carry_in | input | 1 | Carry into bit 0 of the adder |
| result | output | 16 | Final ALU output |
| is_zero | output | 1 | Result is all zeros |
| is_neg | output | 1 | MSB of result |

## Verification
The hardest situation to reach is a carry that travels through the whole ripple chain and falls off the top, because it needs operands whose conditioned forms sum to exactly 2^16. The bench reaches this with an all-ones operand plus one, and with an all-ones operand plus a carry-in, which also gives a zero result. Carry propagation into the MSB alone is covered with 0x7FFF plus a carry-in. A pseudo-random sweep over every control combination then compares the outputs against a model written from the requirements.

// File: rtl/zn_alu_pkg.sv
package zn_alu_pkg;

    typedef struct packed {
        logic zero;
        logic inv;
    } cond_t;

    typedef struct packed {
        cond_t x;
        cond_t y;
        logic  fn_add;
        logic  out_inv;
        logic  cin;
    } alu_ctrl_t;

    typedef struct packed {
        logic s;
        logic c;
    } fa_t;

    function automatic fa_t full_add(input logic a, input logic b, input logic ci);
        fa_t r;
        r.s = a ^ b ^ ci;
        r.c = (a & b) | (ci & (a ^ b));
        return r;
    endfunction

    function automatic logic cond_bit(input logic d, input cond_t c);
        return (d & ~c.zero) ^ c.inv;
    endfunction

endpackage

// File: rtl/zn_operand_cond.sv
module zn_operand_cond
    import zn_alu_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0] d,
    input  cond_t            ctl,
    output logic [WIDTH-1:0] q
);

    genvar i;
    generate
        for (i = 0; i < WIDTH; i++) begin : g_bit
            assign q[i] = cond_bit(d[i], ctl);
        end
    endgenerate

    always_comb begin
        // R1
        zero_first_chk: assert (!(ctl.zero && !ctl.inv) || q == '0);
        // R3
        zero_inv_ones_chk: assert (!(ctl.zero && ctl.inv) || q == {WIDTH{1'b1}});
        // R2
        pass_chk: assert (ctl.zero || ctl.inv || q == d);
    end

endmodule

// File: rtl/zn_ripple_adder.sv
module zn_ripple_adder
    import zn_alu_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic             cin,
    output logic [WIDTH-1:0] sum
);

    localparam int CW = WIDTH + 1;

    logic [WIDTH:0] carry;
    fa_t  [WIDTH-1:0] stage;

    assign carry[0] = cin;

    genvar i;
    generate
        for (i = 0; i < WIDTH; i++) begin : g_fa
            assign stage[i]    = full_add(a[i], b[i], carry[i]);
            assign sum[i]      = stage[i].s;
            assign carry[i+1]  = stage[i].c;
        end
    endgenerate

    always_comb begin
        // R5
        ripple_sum_chk: assert ({carry[WIDTH], sum} ==
                                (CW'(a) + CW'(b) + CW'(cin)));
    end

endmodule

// File: rtl/zn_func_out.sv
module zn_func_out #(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0] xa,
    input  logic [WIDTH-1:0] yb,
    input  logic [WIDTH-1:0] sum,
    input  logic             fn_add,
    input  logic             out_inv,
    output logic [WIDTH-1:0] y
);

    logic [WIDTH-1:0] and_v;
    logic [WIDTH-1:0] pick;

    genvar i;
    generate
        for (i = 0; i < WIDTH; i++) begin : g_bit
            assign and_v[i] = xa[i] & yb[i];
            assign pick[i]  = fn_add ? sum[i] : and_v[i];
            assign y[i]     = pick[i] ^ out_inv;
        end
    endgenerate

endmodule

// File: rtl/zn_flags.sv
module zn_flags #(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0] v,
    output logic             zero,
    output logic             neg
);

    assign zero = ~|v;
    assign neg  = v[WIDTH-1];

endmodule

// File: rtl/zn_alu.sv
module zn_alu
    import zn_alu_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0] x_in,
    input  logic [WIDTH-1:0] y_in,
    input  logic             x_zero,
    input  logic             x_inv,
    input  logic             y_zero,
    input  logic             y_inv,
    input  logic             fn_add,
    input  logic             out_inv,
    input  logic             carry_in,
    output logic [WIDTH-1:0] result,
    output logic             is_zero,
    output logic             is_neg
);

    alu_ctrl_t        ctl;
    logic [WIDTH-1:0] xc;
    logic [WIDTH-1:0] yc;
    logic [WIDTH-1:0] sum;

    assign ctl = '{x: '{zero: x_zero, inv: x_inv},
                   y: '{zero: y_zero, inv: y_inv},
                   fn_add: fn_add, out_inv: out_inv, cin: carry_in};

    zn_operand_cond #(.WIDTH(WIDTH)) u_cond_x (.d(x_in), .ctl(ctl.x), .q(xc));
    zn_operand_cond #(.WIDTH(WIDTH)) u_cond_y (.d(y_in), .ctl(ctl.y), .q(yc));

    zn_ripple_adder #(.WIDTH(WIDTH)) u_add (
        .a(xc), .b(yc), .cin(ctl.cin), .sum(sum)
    );

    zn_func_out #(.WIDTH(WIDTH)) u_out (
        .xa(xc), .yb(yc), .sum(sum),
        .fn_add(ctl.fn_add), .out_inv(ctl.out_inv), .y(result)
    );

    zn_flags #(.WIDTH(WIDTH)) u_flags (.v(result), .zero(is_zero), .neg(is_neg));

    always_comb begin
        // R8
        flag_excl_chk: assert ($onehot0({is_zero, is_neg}));
        // R7
        zero_flag_chk: assert (!is_zero || result == '0);
        // R4
        and_path_chk: assert (fn_add || ((result ^ {WIDTH{out_inv}}) == (xc & yc)));
        // R6
        add_path_chk: assert (!fn_add || ((result ^ {WIDTH{out_inv}}) == sum));
    end

endmodule

// File: tb/test_zn_alu.sv
module test_zn_alu;

    localparam int W = 16;
    localparam int NV = 15;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic [W-1:0] x_in, y_in, result;
    logic x_zero, x_inv, y_zero, y_inv, fn_add, out_inv, carry_in;
    logic is_zero, is_neg;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    zn_alu #(.WIDTH(W)) i_zn_alu (
        .x_in(x_in), .y_in(y_in), .x_zero(x_zero), .x_inv(x_inv),
        .y_zero(y_zero), .y_inv(y_inv), .fn_add(fn_add), .out_inv(out_inv),
        .carry_in(carry_in), .result(result), .is_zero(is_zero), .is_neg(is_neg)
    );

    // {zx,nx,zy,ny,f,no,cin}, x, y, expected
    localparam logic [54:0] VEC [NV] = '{
        {7'b1010100, 16'h1234, 16'h0F0F, 16'h0000}, // R9 zero
        {7'b1111110, 16'h1234, 16'h0F0F, 16'h0001}, // R9 one
        {7'b0000100, 16'h1234, 16'h0F0F, 16'h2143}, // R4 add
        {7'b0000000, 16'h1234, 16'h0F0F, 16'h0204}, // R4 and
        {7'b0000010, 16'h1234, 16'h0F0F, 16'hFDFB}, // R6
        {7'b0010100, 16'h1234, 16'h0F0F, 16'h1234}, // R2
        {7'b0011100, 16'h1234, 16'h0F0F, 16'h1233}, // R3 x-1
        {7'b0000101, 16'h1234, 16'h0F0F, 16'h2144}, // R5 cin
        {7'b0100110, 16'h1234, 16'h0F0F, 16'h0325}, // x-y
        {7'b0001110, 16'h1234, 16'h0F0F, 16'hFCDB}, // y-x
        {7'b0000100, 16'hFFFF, 16'h0001, 16'h0000}, // R5 wrap
        {7'b1110100, 16'h1234, 16'h0F0F, 16'hFFFF}, // R1 R3 -1
        {7'b0100000, 16'h1234, 16'h0F0F, 16'h0D0B}, // R3 ~x&y
        {7'b0000101, 16'h7FFF, 16'h0000, 16'h8000}, // R5 ripple to MSB
        {7'b1010101, 16'h1234, 16'h0F0F, 16'h0001}  // R5 0+0+1
    };

    function automatic logic [W-1:0] model(input logic [6:0] c,
                                           input logic [W-1:0] x,
                                           input logic [W-1:0] y);
        logic [W-1:0] a, b, r;
        a = c[6] ? '0 : x;
        a = c[5] ? ~a : a;
        b = c[4] ? '0 : y;
        b = c[3] ? ~b : b;
        r = c[2] ? W'(a + b + W'(c[0])) : (a & b);
        return c[1] ? ~r : r;
    endfunction

    task automatic drive(input logic [6:0] c, input logic [W-1:0] x,
                         input logic [W-1:0] y);
        {x_zero, x_inv, y_zero, y_inv, fn_add, out_inv, carry_in} = c;
        x_in = x;
        y_in = y;
    endtask

    task automatic check(input string req, input logic [W-1:0] exp);
        checks++;
        if (result !== exp) begin
            fails++;
            $display("FAIL %s result act=%h exp=%h", req, result, exp);
        end
        checks++;
        if (is_zero !== (exp == '0)) begin
            fails++;
            $display("FAIL R7 is_zero act=%b exp=%b", is_zero, exp == '0);
        end
        checks++;
        if (is_neg !== exp[W-1]) begin
            fails++;
            $display("FAIL R8 is_neg act=%b exp=%b", is_neg, exp[W-1]);
        end
    endtask

    initial begin
        drive(7'b0, '0, '0);
        @(negedge clk);
        check("R7 idle", 16'h0000);

        for (int k = 0; k < NV; k++) begin
            drive(VEC[k][54:48], VEC[k][47:32], VEC[k][31:16]);
            @(negedge clk);
            check($sformatf("R4 vec%0d", k), VEC[k][15:0]);
        end

        // R10: carry_in ignored on AND path
        drive(7'b0000001, 16'h1234, 16'h0F0F);
        @(negedge clk);
        check("R10", 16'h0204);
        drive(7'b0000011, 16'hFFFF, 16'hFFFF);
        @(negedge clk);
        check("R10", 16'h0000);

        // R5: carry-in alone wraps all-ones to zero
        drive(7'b0000101, 16'hFFFF, 16'h0000);
        @(negedge clk);
        check("R5 wrap cin", 16'h0000);

        // R11: change between edges, outputs follow at once
        drive(7'b0000100, 16'h0001, 16'h0001);
        @(negedge clk);
        #1 x_in = 16'h0002;
        #1 check("R11", 16'h0003);

        // R1 R2 R3 sweep of every control combination
        begin
            logic [31:0] lfsr;
            lfsr = 32'hACE1_1234;
            for (int n = 0; n < 512; n++) begin
                lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
                drive(7'(n), lfsr[15:0], lfsr[31:16]);
                @(negedge clk);
                check("R1 sweep", model(7'(n), lfsr[15:0], lfsr[31:16]));
            end
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog act=timeout exp=finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

endmodule